// File: doc/BRIEF.md
# Block Cipher Offload Command Controller

This block sequences one bulk cipher job for a 128-bit block cipher core. Software programs a source address, a destination address, a byte count, a four-word key and a four-word chaining value through a small word-addressed register port. It then writes a control word with the run bit set. The controller walks the buffer one 16-byte block at a time. For each block it reads the block over a simple request/acknowledge memory port, hands it to an external cipher core over a valid/ready port, and writes the result back. It applies electronic-codebook or cipher-block-chaining in either direction on its own.

When the job ends, the run bit drops to zero and a sticky completion flag is raised. An interrupt line follows that flag unless software masks it. After a chained job the chaining-value registers hold the last ciphertext block, so a long message can be split across several jobs. A request with a bad length or a misaligned address is refused at once. It is flagged as an error and makes no memory traffic.

Register word offsets (4-bit `reg_addr` is a word index): 0 control, 1 interrupt, 4 source, 5 destination, 6 length, 8 to 11 key, 12 to 15 chaining value. Key word i and chaining word i map to block bits [32i+31:32i]. Unmapped words read as zero.

Top module: `cipher_offload_ctrl`

## Requirements
- R1: Writing control with bit 0 set while idle starts a job; control bit 0 reads 1 from the next cycle for as long as the job runs, and returns to 0 by itself when the job ends.
- R2: Control bit 1 (1 encrypt, 0 decrypt) drives `cph_encrypt`; control bits 2, 3 and 4 are stored and read back at their positions; key words read as 0; chaining words read back what was written; writes to words 0 and 4 to 15 are ignored while a job runs.
- R3: If the length is not a multiple of 16, or the source or destination address has a nonzero low nibble, a start sets control bit 8 (error), sets the completion flag, leaves control bit 0 at 0 in the following cycle and makes no memory request; a valid start clears bit 8.
- R4: With control bit 5 at 0 (codebook mode), destination block i is the core's output for source block i, with the core's key being the key registers.
- R5: Chained encryption (bit 5 = 1, bit 1 = 1): the core input for block i is source block i XOR V, the core output is written out and becomes the next V, and V starts at the chaining registers.
- R6: Chained decryption (bit 5 = 1, bit 1 = 0): destination block i is the core output XOR V, and source block i becomes the next V.
- R7: After a chained job the chaining registers hold the final V: the last output block when encrypting, the last input block when decrypting; after a codebook job they are unchanged.
- R8: Interrupt register bit 16 is set when a job ends, is cleared by writing 1 to bit 16, and is unaffected by writing 0 there.
- R9: `irq` is high exactly when interrupt bit 16 is set and interrupt bit 0 (mask) is 0.
- R10: Block i is read from source + 16*i before being written to destination + 16*i, in ascending order; a memory request holds its address and direction until acknowledged, and every address is 16-byte aligned.
- R11: A valid start with length 0 ends the job with no memory request and sets the completion flag.
- R12: `cph_in_valid` with its data holds until `cph_in_ready`; at most one of memory request, core input valid and core output ready is active at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write when 1 |
| mem_addr | output | AW (32) | Byte address of the block |
| mem_wdata | output | 128 | Write block |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 128 | Read block, valid with `mem_ack` |
| cph_key | output | 128 | Key to the cipher core |
| cph_encrypt | output | 1 | Core direction, 1 encrypt |
| cph_in_valid | output | 1 | Block offered to the core |
| cph_in_ready | input | 1 | Core accepts the block |
| cph_in_data | output | 128 | Block to the core |
| cph_out_valid | input | 1 | Core result available |
| cph_out_ready | output | 1 | Controller takes the result |
| cph_out_data | input | 128 | Core result |

## Verification
The properties take for granted that the memory raises `mem_ack` only while `mem_req` is high and for a single cycle. They also assume the cipher core presents a result only after it has accepted a block and holds that result until it is taken. The bench's memory model answers only live requests, with a latency that cycles between zero and two wait cycles. Its stand-in core holds one block at a time and blocks its input while a result is pending. Register writes come only from the bench's write task, one per cycle, so the start request never coincides with an interrupt-register write.

// File: rtl/ofl_pkg.sv
// Shared constants and types for the cipher offload controller.
// Assumes a 128-bit cipher block and a 32-bit register port.
package ofl_pkg;
    localparam int BLK_W     = 128;
    localparam int BLK_BYTES = BLK_W / 8;
    localparam int OFS_W     = $clog2(BLK_BYTES);
    localparam int REG_W     = 32;
    localparam int RA_W      = 4;

    localparam logic [RA_W-1:0] RA_CTRL = 4'd0;
    localparam logic [RA_W-1:0] RA_INT  = 4'd1;
    localparam logic [RA_W-1:0] RA_SRC  = 4'd4;
    localparam logic [RA_W-1:0] RA_DST  = 4'd5;
    localparam logic [RA_W-1:0] RA_LEN  = 4'd6;
    localparam logic [1:0]      RG_KEY  = 2'b10;
    localparam logic [1:0]      RG_IV   = 2'b11;

    localparam int CB_RUN  = 0;
    localparam int CB_ENC  = 1;
    localparam int CB_CBC  = 5;
    localparam int CB_ERR  = 8;
    localparam int IB_MASK = 0;
    localparam int IB_DONE = 16;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_RD, SQ_CIN, SQ_COUT, SQ_WR, SQ_FIN
    } sq_state_t;
endpackage

// File: rtl/ofl_regs.sv
// Register file of the offload controller: job parameters, key, chaining
// value, run/error bits and the interrupt register. Checks a start request
// against the length and alignment rules and launches the sequencer.
// Assumes one register access per cycle; reads are combinational.
module ofl_regs
    import ofl_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [RA_W-1:0]  addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             fin,
    input  logic             iv_upd,
    input  logic [BLK_W-1:0] iv_new,
    output logic             go,
    output logic             busy,
    output logic             done_flag,
    output logic             int_mask,
    output logic [AW-1:0]    src,
    output logic [AW-1:0]    dst,
    output logic [LW-1:0]    len,
    output logic             enc,
    output logic             cbc,
    output logic [BLK_W-1:0] key,
    output logic [BLK_W-1:0] iv
);
    localparam int NWORD = BLK_W / REG_W;

    logic [5:1]                  mode_q;
    logic                        busy_q, err_q, go_q, mask_q, done_q;
    logic [AW-1:0]               src_q, dst_q;
    logic [LW-1:0]               len_q;
    logic [NWORD-1:0][REG_W-1:0] key_q, iv_q;
    logic                        bad_args;

    // Start request is refused when length or either address breaks alignment.
    always_comb begin
        bad_args = (len_q[OFS_W-1:0] != '0) || (src_q[OFS_W-1:0] != '0)
                || (dst_q[OFS_W-1:0] != '0);
    end

    // Register updates, start decision, completion and flag clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            busy_q <= 1'b0;
            err_q  <= 1'b0;
            go_q   <= 1'b0;
            mask_q <= 1'b0;
            done_q <= 1'b0;
            src_q  <= '0;
            dst_q  <= '0;
            len_q  <= '0;
            key_q  <= '0;
            iv_q   <= '0;
        end else begin
            go_q <= 1'b0;
            if (wr && !busy_q) begin
                if (addr == RA_CTRL) begin
                    mode_q <= wdata[5:1];
                    if (wdata[CB_RUN]) begin
                        if (bad_args) begin
                            err_q  <= 1'b1;
                            done_q <= 1'b1;
                        end else begin
                            err_q  <= 1'b0;
                            busy_q <= 1'b1;
                            go_q   <= 1'b1;
                        end
                    end
                end else if (addr == RA_SRC) begin
                    src_q <= wdata[AW-1:0];
                end else if (addr == RA_DST) begin
                    dst_q <= wdata[AW-1:0];
                end else if (addr == RA_LEN) begin
                    len_q <= wdata[LW-1:0];
                end else if (addr[3:2] == RG_KEY) begin
                    key_q[addr[1:0]] <= wdata;
                end else if (addr[3:2] == RG_IV) begin
                    iv_q[addr[1:0]] <= wdata;
                end
            end
            if (wr && addr == RA_INT) begin
                mask_q <= wdata[IB_MASK];
                if (wdata[IB_DONE]) begin
                    done_q <= 1'b0;
                end
            end
            if (busy_q && iv_upd) begin
                iv_q <= iv_new;
            end
            if (fin) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    // Read multiplexer; key words are write-only.
    always_comb begin
        rdata = '0;
        if (addr == RA_CTRL) begin
            rdata[CB_RUN] = busy_q;
            rdata[5:1]    = mode_q;
            rdata[CB_ERR] = err_q;
        end else if (addr == RA_INT) begin
            rdata[IB_MASK] = mask_q;
            rdata[IB_DONE] = done_q;
        end else if (addr == RA_SRC) begin
            rdata[AW-1:0] = src_q;
        end else if (addr == RA_DST) begin
            rdata[AW-1:0] = dst_q;
        end else if (addr == RA_LEN) begin
            rdata[LW-1:0] = len_q;
        end else if (addr[3:2] == RG_IV) begin
            rdata = iv_q[addr[1:0]];
        end
    end

    assign go        = go_q;
    assign busy      = busy_q;
    assign done_flag = done_q;
    assign int_mask  = mask_q;
    assign src       = src_q;
    assign dst       = dst_q;
    assign len       = len_q;
    assign enc       = mode_q[CB_ENC];
    assign cbc       = mode_q[CB_CBC];
    assign key       = key_q;
    assign iv        = iv_q;
endmodule

// File: rtl/ofl_chain.sv
// Chaining arithmetic around the cipher core: input whitening for chained
// encryption, output unwhitening for chained decryption, and the choice of
// the next chaining value. Purely combinational.
module ofl_chain
    import ofl_pkg::*;
(
    input  logic             enc,
    input  logic             cbc,
    input  logic [BLK_W-1:0] in_blk,
    input  logic [BLK_W-1:0] chain,
    input  logic [BLK_W-1:0] core_out,
    output logic [BLK_W-1:0] core_in,
    output logic [BLK_W-1:0] result,
    output logic [BLK_W-1:0] next_chain
);
    // Mix the chaining value in before or after the core depending on direction.
    always_comb begin
        core_in    = (cbc && enc)  ? (in_blk ^ chain)   : in_blk;
        result     = (cbc && !enc) ? (core_out ^ chain) : core_out;
        next_chain = enc ? core_out : in_blk;
    end
endmodule

// File: rtl/ofl_seq.sv
// Block sequencer: for each 16-byte block reads the source, passes it through
// the cipher core, writes the destination, then steps the offset until the
// programmed length is covered. Assumes the length is a multiple of the block
// size and that parameters stay stable while it runs.
module ofl_seq
    import ofl_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [AW-1:0]    src,
    input  logic [AW-1:0]    dst,
    input  logic [LW-1:0]    len,
    input  logic             cbc,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [BLK_W-1:0] mem_wdata,
    input  logic             mem_ack,
    input  logic [BLK_W-1:0] mem_rdata,
    output logic             cph_in_valid,
    input  logic             cph_in_ready,
    output logic             cph_out_ready,
    input  logic             cph_out_valid,
    output logic [BLK_W-1:0] in_blk,
    input  logic [BLK_W-1:0] result,
    output logic             iv_upd,
    output logic             fin
);
    sq_state_t        state_q;
    logic [LW-1:0]    off_q, next_off;
    logic [BLK_W-1:0] in_q, out_q;

    // Offset of the following block.
    always_comb begin
        next_off = off_q + LW'(BLK_BYTES);
    end

    // Block loop state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            off_q   <= '0;
            in_q    <= '0;
            out_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (go) begin
                    off_q   <= '0;
                    state_q <= (len == '0) ? SQ_FIN : SQ_RD;
                end
                SQ_RD: if (mem_ack) begin
                    in_q    <= mem_rdata;
                    state_q <= SQ_CIN;
                end
                SQ_CIN: if (cph_in_ready) begin
                    state_q <= SQ_COUT;
                end
                SQ_COUT: if (cph_out_valid) begin
                    out_q   <= result;
                    state_q <= SQ_WR;
                end
                SQ_WR: if (mem_ack) begin
                    off_q   <= next_off;
                    state_q <= (next_off == len) ? SQ_FIN : SQ_RD;
                end
                SQ_FIN:  state_q <= SQ_IDLE;
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Port outputs decoded from the current state.
    always_comb begin
        mem_req       = (state_q == SQ_RD) || (state_q == SQ_WR);
        mem_we        = (state_q == SQ_WR);
        mem_addr      = ((state_q == SQ_WR) ? dst : src) + AW'(off_q);
        mem_wdata     = out_q;
        cph_in_valid  = (state_q == SQ_CIN);
        cph_out_ready = (state_q == SQ_COUT);
        iv_upd        = (state_q == SQ_COUT) && cph_out_valid && cbc;
        fin           = (state_q == SQ_FIN);
    end

    assign in_blk = in_q;
endmodule

// File: rtl/cipher_offload_ctrl.sv
// Top of the block cipher offload controller. Joins the register file, the
// block sequencer and the chaining arithmetic. The cipher core is external.
module cipher_offload_ctrl
    import ofl_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             irq,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [127:0]     mem_wdata,
    input  logic             mem_ack,
    input  logic [127:0]     mem_rdata,
    output logic [127:0]     cph_key,
    output logic             cph_encrypt,
    output logic             cph_in_valid,
    input  logic             cph_in_ready,
    output logic [127:0]     cph_in_data,
    input  logic             cph_out_valid,
    output logic             cph_out_ready,
    input  logic [127:0]     cph_out_data
);
    logic             go_w, busy_w, done_w, mask_w, fin_w, iv_upd_w;
    logic             enc_w, cbc_w;
    logic [AW-1:0]    src_w, dst_w;
    logic [LW-1:0]    len_w;
    logic [BLK_W-1:0] iv_w, in_blk_w, result_w, next_chain_w;

    ofl_regs #(.AW(AW), .LW(LW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .fin(fin_w),
        .iv_upd(iv_upd_w), .iv_new(next_chain_w), .go(go_w),
        .busy(busy_w), .done_flag(done_w), .int_mask(mask_w),
        .src(src_w), .dst(dst_w), .len(len_w), .enc(enc_w), .cbc(cbc_w),
        .key(cph_key), .iv(iv_w)
    );

    ofl_seq #(.AW(AW), .LW(LW)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go_w), .src(src_w), .dst(dst_w),
        .len(len_w), .cbc(cbc_w), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .cph_in_valid(cph_in_valid),
        .cph_in_ready(cph_in_ready), .cph_out_ready(cph_out_ready),
        .cph_out_valid(cph_out_valid), .in_blk(in_blk_w),
        .result(result_w), .iv_upd(iv_upd_w), .fin(fin_w)
    );

    ofl_chain u_chain (
        .enc(enc_w), .cbc(cbc_w), .in_blk(in_blk_w), .chain(iv_w),
        .core_out(cph_out_data), .core_in(cph_in_data),
        .result(result_w), .next_chain(next_chain_w)
    );

    // Interrupt follows the sticky completion flag unless masked.
    always_comb begin
        irq         = done_w && !mask_w;
        cph_encrypt = enc_w;
    end
endmodule

// File: rtl/ofl_check.sv
// Protocol and sequencing properties for the offload controller, bound into
// the top. Assumes the memory acknowledges only live requests.
module ofl_check #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          cph_in_valid,
    input logic          cph_in_ready,
    input logic [127:0]  cph_in_data,
    input logic          cph_out_ready,
    input logic          busy,
    input logic          fin,
    input logic          done
);
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    p_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[3:0] == 4'h0);
    p_no_idle_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
    p_cin_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cph_in_valid && !cph_in_ready |=> cph_in_valid && $stable(cph_in_data));
    p_one_phase_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, cph_in_valid, cph_out_ready}));
    p_self_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !busy);
    p_flag_on_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> done);
endmodule

bind cipher_offload_ctrl ofl_check #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_ack(mem_ack), .mem_addr(mem_addr), .cph_in_valid(cph_in_valid),
    .cph_in_ready(cph_in_ready), .cph_in_data(cph_in_data),
    .cph_out_ready(cph_out_ready), .busy(busy_w), .fin(fin_w), .done(done_w)
);

// File: tb/cipher_offload_ctrl_test.sv
module cipher_offload_ctrl_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [3:0]   reg_addr = 4'd0;
    logic [31:0]  reg_wdata = 32'd0;
    logic [31:0]  reg_rdata;
    logic         irq;
    logic         mem_req, mem_we, mem_ack;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata, mem_rdata;
    logic [127:0] cph_key, cph_in_data, cph_out_data;
    logic         cph_encrypt, cph_in_valid, cph_in_ready;
    logic         cph_out_valid, cph_out_ready;

    int nchk = 0;
    int nerr = 0;
    int reqs = 0;
    int acks = 0;
    logic [1:0] wait_q;
    logic       c_full;
    logic [127:0] c_res;
    logic [127:0] mem [0:63];

    localparam logic [31:0] SRC_BASE = 32'h100;
    localparam logic [31:0] DST_BASE = 32'h200;

    always #4 clk = ~clk;

    cipher_offload_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .cph_key(cph_key), .cph_encrypt(cph_encrypt),
        .cph_in_valid(cph_in_valid), .cph_in_ready(cph_in_ready),
        .cph_in_data(cph_in_data), .cph_out_valid(cph_out_valid),
        .cph_out_ready(cph_out_ready), .cph_out_data(cph_out_data)
    );

    function automatic logic [127:0] f_enc(input logic [127:0] x, input logic [127:0] k);
        return {x[63:0], x[127:64]} ^ k;
    endfunction
    function automatic logic [127:0] f_dec(input logic [127:0] y, input logic [127:0] k);
        logic [127:0] z;
        z = y ^ k;
        return {z[63:0], z[127:64]};
    endfunction
    function automatic logic [31:0] wgen(input int seed, input int i);
        return 32'(seed) * 32'h01030507 ^ 32'(i) * 32'h9e3779b9 ^ 32'h5a5a0000;
    endfunction

    // Memory model with 0..2 wait cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wait_q  <= 2'd1;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wait_q == 2'd0) begin
                mem_ack <= 1'b1;
                acks    <= acks + 1;
                wait_q  <= 2'((acks + 1) % 3);
                if (mem_we) mem[mem_addr[9:4]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[9:4]];
            end else begin
                wait_q <= wait_q - 2'd1;
            end
        end
    end

    always @(posedge clk) if (rst_n && mem_req) reqs <= reqs + 1;

    // Stand-in cipher core holding one block.
    assign cph_in_ready  = !c_full;
    assign cph_out_valid = c_full;
    assign cph_out_data  = c_res;
    always @(posedge clk) begin
        if (!rst_n) begin
            c_full <= 1'b0;
            c_res  <= '0;
        end else if (c_full) begin
            if (cph_out_ready) c_full <= 1'b0;
        end else if (cph_in_valid) begin
            c_full <= 1'b1;
            c_res  <= cph_encrypt ? f_enc(cph_in_data, cph_key) : f_dec(cph_in_data, cph_key);
        end
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int n = 0; n < 3000; n++) begin
            rd(4'd0, v);
            if (v[0] == 1'b0) return;
            @(negedge clk);
        end
        check("R1 job never ended", 1, 0);
    endtask

    task automatic run_op(input int nb, input bit enc, input bit cbc, input int seed);
        logic [127:0] key, v, p, o;
        logic [127:0] ivs;
        logic [127:0] exp_blk [0:3];
        logic [31:0] r;
        int req0;
        for (int i = 0; i < 4; i++) begin
            mem[(SRC_BASE >> 4) + i] = {wgen(seed, 4*i), wgen(seed, 4*i+1), wgen(seed, 4*i+2), wgen(seed, 4*i+3)};
            mem[(DST_BASE >> 4) + i] = '0;
        end
        for (int w = 0; w < 4; w++) begin
            key[32*w +: 32] = wgen(seed + 77, w);
            ivs[32*w +: 32] = wgen(seed + 191, w);
            wr(4'(8 + w), key[32*w +: 32]);
            wr(4'(12 + w), ivs[32*w +: 32]);
        end
        wr(4'd4, SRC_BASE);
        wr(4'd5, DST_BASE);
        wr(4'd6, 32'(nb * 16));
        v = ivs;
        for (int i = 0; i < nb; i++) begin
            p = mem[(SRC_BASE >> 4) + i];
            if (enc) begin
                o = f_enc(cbc ? (p ^ v) : p, key);
                if (cbc) v = o;
            end else begin
                o = f_dec(p, key);
                if (cbc) o = o ^ v;
                if (cbc) v = p;
            end
            exp_blk[i] = o;
        end
        req0 = reqs;
        wr(4'd0, {26'd0, cbc, 3'b111, enc, 1'b1});
        rd(4'd0, r);
        check("R1 run bit set after start", r[0], 1);
        wait_idle();
        rd(4'd0, r);
        check("R2 mode bits read back", r[5:1], {cbc, 3'b111, enc});
        check("R3 error bit clear after valid start", r[8], 0);
        for (int i = 0; i < nb; i++)
            check(cbc ? (enc ? "R5 chained encrypt block" : "R6 chained decrypt block") : "R4 codebook block",
                  mem[(DST_BASE >> 4) + i], exp_blk[i]);
        check("R10 block after end untouched", mem[(DST_BASE >> 4) + nb], 0);
        for (int w = 0; w < 4; w++) begin
            rd(4'(12 + w), r);
            check("R7 chaining value after job", r, cbc ? v[32*w +: 32] : ivs[32*w +: 32]);
        end
        if (nb == 0) check("R11 no memory request for zero length", reqs - req0, 0);
        else         check("R10 one request per transfer", reqs >= req0 + 2 * nb, 1);
        rd(4'd1, r);
        check("R8 completion flag set", r[16], 1);
        check("R9 irq with flag and no mask", irq, 1);
        wr(4'd1, 32'h0001_0000);
        rd(4'd1, r);
        check("R8 flag cleared by write of one", r[16], 0);
        check("R9 irq low after clear", irq, 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        for (int n = 0; n < 150000; n++) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        int req0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(4'd0, r);  check("R1 control after reset", r, 0);
        rd(4'd1, r);  check("R8 interrupt reg after reset", r, 0);
        check("R9 irq after reset", irq, 0);
        wr(4'd8, 32'hdeadbeef);
        rd(4'd8, r);  check("R2 key word reads zero", r, 0);

        // Sweep lengths and all four modes.
        for (int nb = 0; nb < 4; nb++)
            for (int m = 0; m < 4; m++)
                run_op(nb, m[0], m[1], nb * 4 + m + 1);

        // Error cases: odd length, misaligned source, misaligned destination.
        for (int e = 0; e < 3; e++) begin
            wr(4'd4, (e == 1) ? SRC_BASE + 32'h8 : SRC_BASE);
            wr(4'd5, (e == 2) ? DST_BASE + 32'h4 : DST_BASE);
            wr(4'd6, (e == 0) ? 32'd24 : 32'd32);
            req0 = reqs;
            wr(4'd0, 32'h3);
            rd(4'd0, r);
            check("R3 run bit low after refused start", r[0], 0);
            check("R3 error bit set", r[8], 1);
            repeat (10) @(negedge clk);
            check("R3 no memory request on error", reqs - req0, 0);
            rd(4'd1, r);
            check("R3 completion flag on error", r[16], 1);
            wr(4'd1, 32'h0001_0000);
        end

        // Writes during a job are ignored; mask holds irq low.
        wr(4'd1, 32'h1);
        wr(4'd4, SRC_BASE);
        wr(4'd5, DST_BASE);
        wr(4'd6, 32'd48);
        wr(4'd0, 32'h3);
        wr(4'd4, 32'h0000_0300);
        rd(4'd4, r);
        check("R2 source write ignored while running", r, SRC_BASE);
        wait_idle();
        rd(4'd1, r);
        check("R9 flag set under mask", r[16], 1);
        check("R9 irq held low by mask", irq, 0);
        wr(4'd1, 32'h0);
        rd(4'd1, r);
        check("R8 writing zero keeps flag", r[16], 1);
        check("R9 irq after unmask", irq, 1);
        wr(4'd1, 32'h0001_0000);
        check("R8 flag clear drops irq", irq, 0);

        finish_run();
    end
endmodule